// File: doc/BRIEF.md
# Four-Phase Command Handshake Requester

This block carries one command from a local client to a remote responder through a pair of register words and a four-phase request/acknowledge exchange. The client presents a get/set flag, an opcode, a port/lane index and a data payload, then pulses `start`. The block first waits until the shared command word shows no request and the responder shows no acknowledge. It then writes the command with its request bit set and polls the response word until acknowledge or error appears. After that it drops the request and waits for acknowledge to fall. At the end it pulses `done` and leaves a status code and the captured reply fields on its outputs.

Polling is paced. Every wait phase samples the remote words once on entry, then again after each fixed gap, and it gives up after a fixed number of samples. The responder must echo the opcode it was sent. If the echo does not match, or the responder raises its error bit, the exchange ends with a fault. The release half of the handshake always runs once a command has been written, including after a failure, so the responder is left idle. The client side has no back-pressure. `start` is a plain pulse and is not queued: a pulse that arrives while `busy` is high is dropped, so a client holds a new command until `busy` is low.

Top module: `cmd_handshake_req`

## Requirements
- R1: No command word is written until a single sample sees both the request bit (bit 31) of `cmd_rd_data` and the acknowledge bit (bit 31) of `rsp_word` at zero. If that never happens within the retry limit, the exchange ends with status 1 (timeout) and no write.
- R2: The command write places request=1 in bit 31, the get/set flag in bit 30, the opcode in bits 29:24, the port/lane in bits 23:16 and the data in bits 15:0.
- R3: If the error bit (bit 30 of `rsp_word`) is seen while acknowledge is awaited, the exchange ends with status 2 (fault).
- R4: If acknowledge arrives with an opcode in `rsp_word` bits 29:24 that differs from the one sent, the status is 2 (fault) and `rsp_valid` stays low.
- R5: On a matching acknowledge the opcode, port/lane (bits 23:16) and data (bits 15:0) of `rsp_word` are captured on `rsp_opcode`, `rsp_port` and `rsp_data`, `rsp_valid` goes high, and a clean release gives status 0 (OK).
- R6: Once acknowledge or error has been seen, or the acknowledge wait has timed out, the same command word is written again with only bit 31 cleared, and `done` waits until acknowledge is sampled low.
- R7: Each wait phase samples its inputs at entry and then every POLL_GAP (16) clocks, at most RETRIES (8) times. Running out of samples without acknowledge gives status 1.
- R8: The first failure of an exchange is the one reported. A timeout in the release phase is reported only when the main exchange succeeded, and then `rsp_valid` still reflects the matching reply.
- R9: Only one exchange is in flight. `busy` is high from the accepted start to the end of the `done` cycle, a `start` pulse during that time is ignored, and no command is written while `busy` is low.
- R10: `done` is a one-cycle pulse. `status` changes only in a `done` cycle and holds until the next one, and `rsp_valid` clears when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange with the presented fields |
| cmd_set | input | 1 | Get (0) or set (1) flag of the command |
| cmd_opcode | input | 6 | Command opcode |
| cmd_port | input | 8 | Port/lane index |
| cmd_data | input | 16 | Command payload |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| status | output | 2 | 0 OK, 1 timeout, 2 fault |
| rsp_valid | output | 1 | Reply fields hold a matching response |
| rsp_opcode | output | 6 | Echoed opcode |
| rsp_port | output | 8 | Reply port/lane field |
| rsp_data | output | 16 | Reply data field |
| cmd_wr_en | output | 1 | Write strobe for the command register |
| cmd_wr_data | output | 32 | Value written to the command register |
| cmd_rd_data | input | 32 | Read-back of the shared command register |
| rsp_word | input | 32 | Responder word: ack, error, opcode, port/lane, data |

## Verification
The hardest case to reach is a failure that lands on top of an earlier one: a mismatched or successful acknowledge that the responder then never releases. Only that case shows whether the first failure wins over the release timeout. The bench's behavioural responder has mode switches for acknowledge delay, error instead of acknowledge, a corrupted opcode echo, a stuck acknowledge and a foreign request bit. The stuck-acknowledge switch is combined with both a clean reply and a corrupted echo. A sweep over opcodes and acknowledge delays, with the last delay near the end of the retry window, covers the paced polling.

// File: rtl/chs_pkg.sv
package chs_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_FAULT   = 2'd2
  } stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR_CHK,
    S_ISSUE,
    S_WAIT_ACK,
    S_RELEASE,
    S_WAIT_DROP,
    S_FINISH
  } fsm_e;

endpackage

// File: rtl/chs_word_pack.sv
module chs_word_pack #(
  parameter int OPC_W  = 6,
  parameter int PORT_W = 8,
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 + OPC_W + PORT_W + DATA_W
) (
  input  logic              req,
  input  logic              flag,
  input  logic [OPC_W-1:0]  opc,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  // Top two bits are the handshake and qualifier flags, then the fields.
  assign word = {req, flag, opc, port, data};
endmodule

// File: rtl/chs_word_unpack.sv
module chs_word_unpack #(
  parameter int OPC_W  = 6,
  parameter int PORT_W = 8,
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 + OPC_W + PORT_W + DATA_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              hs_bit,
  output logic              flag,
  output logic [OPC_W-1:0]  opc,
  output logic [PORT_W-1:0] port,
  output logic [DATA_W-1:0] data
);
  assign {hs_bit, flag, opc, port, data} = word;
endmodule

// File: rtl/chs_poll_pacer.sv
module chs_poll_pacer #(
  parameter int POLL_GAP = 16,
  parameter int RETRIES  = 8,
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1,
  localparam int RW = $clog2(RETRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // restart pacing for a new wait phase
  input  logic active,   // owner is in a wait phase
  output logic sample,   // evaluate the remote words this cycle
  output logic last      // this sample is the final one allowed
);
  logic [RW-1:0] tries_q;

  generate
    if (POLL_GAP > 1) begin : g_gap
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
          gap_q <= '0;
        end else if (active) begin
          if (gap_q == '0) gap_q <= GW'(POLL_GAP - 1);
          else             gap_q <= gap_q - 1'b1;
        end
      end
      assign sample = active && (gap_q == '0);
    end else begin : g_nogap
      assign sample = active;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || arm)   tries_q <= '0;
    else if (sample)     tries_q <= tries_q + 1'b1;
  end

  assign last = (tries_q == RW'(RETRIES - 1));
endmodule

// File: rtl/cmd_handshake_req.sv
module cmd_handshake_req
  import chs_pkg::*;
#(
  parameter int OPC_W    = 6,
  parameter int PORT_W   = 8,
  parameter int DATA_W   = 16,
  parameter int POLL_GAP = 16,
  parameter int RETRIES  = 8,
  localparam int WORD_W  = 2 + OPC_W + PORT_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_set,
  input  logic [OPC_W-1:0]  cmd_opcode,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              rsp_valid,
  output logic [OPC_W-1:0]  rsp_opcode,
  output logic [PORT_W-1:0] rsp_port,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cmd_wr_en,
  output logic [WORD_W-1:0] cmd_wr_data,
  input  logic [WORD_W-1:0] cmd_rd_data,
  input  logic [WORD_W-1:0] rsp_word
);

  fsm_e  state_q;
  stat_e err_q, status_q;

  logic              op_set_q;
  logic [OPC_W-1:0]  op_opc_q;
  logic [PORT_W-1:0] op_port_q;
  logic [DATA_W-1:0] op_data_q;

  logic              match_q, valid_q;
  logic [OPC_W-1:0]  cap_opc_q;
  logic [PORT_W-1:0] cap_port_q;
  logic [DATA_W-1:0] cap_data_q;

  // Response field split
  logic              rsp_ack, rsp_err;
  logic [OPC_W-1:0]  rsp_opc_f;
  logic [PORT_W-1:0] rsp_port_f;
  logic [DATA_W-1:0] rsp_data_f;

  chs_word_unpack #(.OPC_W(OPC_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) rsp_split_i (
    .word   (rsp_word),
    .hs_bit (rsp_ack),
    .flag   (rsp_err),
    .opc    (rsp_opc_f),
    .port   (rsp_port_f),
    .data   (rsp_data_f)
  );

  // Only the request bit of the shared command register matters here.
  logic rd_req;
  logic unused_rd;
  assign rd_req    = cmd_rd_data[WORD_W-1];
  assign unused_rd = ^cmd_rd_data[WORD_W-2:0];

  // Outgoing command word
  logic issue_req;
  assign issue_req = (state_q == S_ISSUE);

  chs_word_pack #(.OPC_W(OPC_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) cmd_build_i (
    .req  (issue_req),
    .flag (op_set_q),
    .opc  (op_opc_q),
    .port (op_port_q),
    .data (op_data_q),
    .word (cmd_wr_data)
  );

  assign cmd_wr_en = (state_q == S_ISSUE) || (state_q == S_RELEASE);

  // Poll pacing shared by the three wait phases
  logic poll_arm, poll_active, poll_sample, poll_last;
  logic accept;

  assign accept      = (state_q == S_IDLE) && start;
  assign poll_arm    = accept || (state_q == S_ISSUE) || (state_q == S_RELEASE);
  assign poll_active = (state_q == S_CLEAR_CHK) || (state_q == S_WAIT_ACK) ||
                       (state_q == S_WAIT_DROP);

  chs_poll_pacer #(.POLL_GAP(POLL_GAP), .RETRIES(RETRIES)) pacer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (poll_arm),
    .active (poll_active),
    .sample (poll_sample),
    .last   (poll_last)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      err_q      <= ST_OK;
      status_q   <= ST_OK;
      op_set_q   <= 1'b0;
      op_opc_q   <= '0;
      op_port_q  <= '0;
      op_data_q  <= '0;
      match_q    <= 1'b0;
      valid_q    <= 1'b0;
      cap_opc_q  <= '0;
      cap_port_q <= '0;
      cap_data_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            op_set_q  <= cmd_set;
            op_opc_q  <= cmd_opcode;
            op_port_q <= cmd_port;
            op_data_q <= cmd_data;
            err_q     <= ST_OK;
            match_q   <= 1'b0;
            valid_q   <= 1'b0;
            state_q   <= S_CLEAR_CHK;
          end
        end

        S_CLEAR_CHK: begin
          if (poll_sample) begin
            if (!rd_req && !rsp_ack) begin
              state_q <= S_ISSUE;
            end else if (poll_last) begin
              status_q <= ST_TIMEOUT;
              state_q  <= S_FINISH;
            end
          end
        end

        S_ISSUE: state_q <= S_WAIT_ACK;

        S_WAIT_ACK: begin
          if (poll_sample) begin
            if (rsp_err) begin
              err_q   <= ST_FAULT;
              state_q <= S_RELEASE;
            end else if (rsp_ack) begin
              if (rsp_opc_f == op_opc_q) begin
                match_q    <= 1'b1;
                cap_opc_q  <= rsp_opc_f;
                cap_port_q <= rsp_port_f;
                cap_data_q <= rsp_data_f;
              end else begin
                err_q <= ST_FAULT;
              end
              state_q <= S_RELEASE;
            end else if (poll_last) begin
              err_q   <= ST_TIMEOUT;
              state_q <= S_RELEASE;
            end
          end
        end

        S_RELEASE: state_q <= S_WAIT_DROP;

        S_WAIT_DROP: begin
          if (poll_sample) begin
            if (!rsp_ack) begin
              status_q <= err_q;
              valid_q  <= match_q;
              state_q  <= S_FINISH;
            end else if (poll_last) begin
              // Earlier failure takes precedence over the release timeout.
              status_q <= (err_q != ST_OK) ? err_q : ST_TIMEOUT;
              valid_q  <= match_q;
              state_q  <= S_FINISH;
            end
          end
        end

        S_FINISH: state_q <= S_IDLE;

        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_FINISH);
  assign status     = status_q;
  assign rsp_valid  = valid_q;
  assign rsp_opcode = cap_opc_q;
  assign rsp_port   = cap_port_q;
  assign rsp_data   = cap_data_q;

endmodule

// File: rtl/chs_checker.sv
module chs_checker #(
  parameter int OPC_W  = 6,
  parameter int PORT_W = 8,
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 + OPC_W + PORT_W + DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic              rsp_valid,
  input logic [OPC_W-1:0]  rsp_opcode,
  input logic              cmd_wr_en,
  input logic [WORD_W-1:0] cmd_wr_data,
  input logic [WORD_W-1:0] cmd_rd_data,
  input logic [WORD_W-1:0] rsp_word
);
  localparam int HI = WORD_W - 1;

  logic [WORD_W-1:0] sent_q;
  logic unused_chk;
  assign unused_chk = ^cmd_rd_data[HI-1:0] ^ ^rsp_word[HI-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) sent_q <= '0;
    else if (cmd_wr_en && cmd_wr_data[HI]) sent_q <= cmd_wr_data;
  end

  // R1: a request write follows a sample with both handshake bits low
  a_r1_issue_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && cmd_wr_data[HI]) |-> $past(!cmd_rd_data[HI] && !rsp_word[HI]));

  // R4: a valid reply carries the opcode that was sent
  a_r4_valid_echo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_opcode == sent_q[HI-2 -: OPC_W]));

  // R6: the release write repeats the command with request cleared
  a_r6_release_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && !cmd_wr_data[HI]) |-> (cmd_wr_data[HI-1:0] == sent_q[HI-1:0]));

  // R9: nothing is written outside an exchange
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_wr_en);

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: status moves only together with done
  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done);
endmodule

bind cmd_handshake_req chs_checker #(
  .OPC_W(OPC_W), .PORT_W(PORT_W), .DATA_W(DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .status      (status),
  .rsp_valid   (rsp_valid),
  .rsp_opcode  (rsp_opcode),
  .cmd_wr_en   (cmd_wr_en),
  .cmd_wr_data (cmd_wr_data),
  .cmd_rd_data (cmd_rd_data),
  .rsp_word    (rsp_word)
);

// File: tb/cmd_handshake_req_tb_top.sv
module cmd_handshake_req_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0, cmd_set = 1'b0;
  logic [5:0]  cmd_opcode = '0;
  logic [7:0]  cmd_port = '0;
  logic [15:0] cmd_data = '0;
  logic        busy, done, rsp_valid, cmd_wr_en;
  logic [1:0]  status;
  logic [5:0]  rsp_opcode;
  logic [7:0]  rsp_port;
  logic [15:0] rsp_data;
  logic [31:0] cmd_wr_data, cmd_rd_data, rsp_word;

  cmd_handshake_req dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_set(cmd_set),
    .cmd_opcode(cmd_opcode), .cmd_port(cmd_port), .cmd_data(cmd_data),
    .busy(busy), .done(done), .status(status), .rsp_valid(rsp_valid),
    .rsp_opcode(rsp_opcode), .rsp_port(rsp_port), .rsp_data(rsp_data),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_data(cmd_rd_data), .rsp_word(rsp_word)
  );

  // Behavioural responder
  int          m_ack_delay = 0, m_drop_delay = 0;
  logic        m_err = 0, m_never = 0, m_stuck = 0, m_foreign = 0, m_clr = 0;
  logic [5:0]  m_opc_xor = '0;

  logic [31:0] cmd_reg;
  logic        ack_r, err_r;
  logic [5:0]  r_opc;
  logic [7:0]  r_port;
  logic [15:0] r_data;
  int          mcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || m_clr) begin
      cmd_reg <= '0; ack_r <= 0; err_r <= 0; mcnt <= 0;
      r_opc <= '0; r_port <= '0; r_data <= '0;
    end else begin
      if (cmd_wr_en) cmd_reg <= cmd_wr_data;
      if (cmd_reg[31] && !ack_r && !err_r && !m_never) begin
        if (mcnt >= m_ack_delay) begin
          if (m_err) err_r <= 1'b1;
          else begin
            ack_r  <= 1'b1;
            r_opc  <= cmd_reg[29:24] ^ m_opc_xor;
            r_port <= cmd_reg[23:16] ^ 8'h5A;
            r_data <= ~cmd_reg[15:0];
          end
          mcnt <= 0;
        end else mcnt <= mcnt + 1;
      end else if (!cmd_reg[31] && (ack_r || err_r) && !m_stuck) begin
        if (mcnt >= m_drop_delay) begin
          ack_r <= 0; err_r <= 0; mcnt <= 0;
        end else mcnt <= mcnt + 1;
      end
    end
  end

  assign rsp_word    = {ack_r, err_r, r_opc, r_port, r_data};
  assign cmd_rd_data = cmd_reg | {m_foreign, 31'b0};

  // Port-level write and done observers
  int          n_set_wr = 0, n_clr_wr = 0, n_done = 0;
  logic [31:0] last_set = '0, last_clr = '0;
  always_ff @(posedge clk) begin
    if (cmd_wr_en && cmd_wr_data[31]) begin n_set_wr <= n_set_wr + 1; last_set <= cmd_wr_data; end
    if (cmd_wr_en && !cmd_wr_data[31]) begin n_clr_wr <= n_clr_wr + 1; last_clr <= cmd_wr_data; end
    if (done) n_done <= n_done + 1;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  localparam logic [1:0] E_OK = 2'd0, E_TO = 2'd1, E_FLT = 2'd2;

  // One exchange; returns cycles from the start edge to the done cycle.
  task automatic run_x(input logic s, input logic [5:0] o, input logic [7:0] p,
                       input logic [15:0] d, input logic [1:0] es, input logic ev,
                       input string rq, output int lat);
    logic [31:0] exp_w;
    exp_w = {1'b1, s, o, p, d};
    @(negedge clk);
    cmd_set = s; cmd_opcode = o; cmd_port = p; cmd_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    chk(rsp_valid == 1'b0, "R10", "valid cleared on start", rsp_valid, 0);
    while (!done && lat < 3000) begin @(negedge clk); lat++; end
    chk(done == 1'b1, rq, "done seen", done, 1);
    chk(status == es, rq, "status", status, es);
    chk(rsp_valid == ev, rq, "rsp_valid", rsp_valid, ev);
    if (ev) begin
      chk(rsp_opcode == o, "R5", "rsp_opcode", rsp_opcode, o);
      chk(rsp_port == (p ^ 8'h5A), "R5", "rsp_port", rsp_port, p ^ 8'h5A);
      chk(rsp_data == ~d, "R5", "rsp_data", rsp_data, ~d);
      chk(last_set == exp_w, "R2", "command word", last_set, exp_w);
      chk(last_clr == {1'b0, exp_w[30:0]}, "R6", "release word", last_clr, {1'b0, exp_w[30:0]});
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, w0, c0, d0;
    logic [1:0] st_hold;
    repeat (3) @(negedge clk);
    // Reset state
    chk(busy == 0 && done == 0, "R9", "idle after reset", {busy, done}, 0);
    chk(status == E_OK && rsp_valid == 0, "R10", "status/valid after reset", {status, rsp_valid}, 0);
    chk(cmd_wr_en == 0, "R9", "no write after reset", cmd_wr_en, 0);
    rst_n = 1'b1;
    settle(2);

    // R5, R2, R6, R7: sweep opcodes and acknowledge delays
    for (int oi = 0; oi < 64; oi += 7) begin
      for (int di = 0; di < 5; di++) begin
        int dl;
        dl = (di == 4) ? 100 : di * 17 + (oi % 5);
        m_ack_delay = dl; m_drop_delay = (dl + oi) % 23;
        w0 = n_set_wr;
        run_x(oi[0], oi[5:0], 8'(oi * 3 + di), 16'(oi * 1000 + dl), E_OK, 1'b1, "R5", lat);
        chk(n_set_wr == w0 + 1, "R2", "one command write", n_set_wr, w0 + 1);
        settle(30);
      end
    end

    // R7: acknowledge never arrives -> timeout after the full retry window
    m_never = 1; m_ack_delay = 0; m_drop_delay = 2;
    c0 = n_clr_wr;
    run_x(1'b1, 6'h15, 8'h22, 16'hBEEF, E_TO, 1'b0, "R7", lat);
    chk(lat >= 110 && lat <= 126, "R7", "ack-wait timeout latency", lat, 118);
    chk(n_clr_wr == c0 + 1, "R6", "release after timeout", n_clr_wr, c0 + 1);
    m_never = 0; model_clear();

    // R1: foreign request holds the bus
    m_foreign = 1; w0 = n_set_wr;
    run_x(1'b0, 6'h01, 8'h01, 16'h0001, E_TO, 1'b0, "R1", lat);
    chk(n_set_wr == w0, "R1", "no write while foreign request", n_set_wr, w0);
    m_foreign = 0; settle(5);

    // R3: error bit -> fault, release still runs
    m_err = 1; m_ack_delay = 3; m_drop_delay = 4; c0 = n_clr_wr;
    run_x(1'b1, 6'h2A, 8'h10, 16'h1234, E_FLT, 1'b0, "R3", lat);
    chk(n_clr_wr == c0 + 1, "R6", "release after error", n_clr_wr, c0 + 1);
    m_err = 0; settle(30);

    // R4: corrupted opcode echo
    m_opc_xor = 6'h04;
    run_x(1'b0, 6'h11, 8'h33, 16'h5555, E_FLT, 1'b0, "R4", lat);
    m_opc_xor = '0; settle(30);

    // R8: clean reply, release never happens -> timeout, reply still valid
    m_stuck = 1; m_ack_delay = 2;
    run_x(1'b1, 6'h3F, 8'hFF, 16'hFFFF, E_TO, 1'b1, "R8", lat);
    // R1: acknowledge still high blocks the next exchange
    w0 = n_set_wr;
    run_x(1'b0, 6'h02, 8'h02, 16'h0002, E_TO, 1'b0, "R1", lat);
    chk(n_set_wr == w0, "R1", "no write while ack high", n_set_wr, w0);
    model_clear();

    // R8: fault first, then stuck release -> fault reported
    m_opc_xor = 6'h20;
    run_x(1'b1, 6'h07, 8'h08, 16'h0900, E_FLT, 1'b0, "R8", lat);
    m_opc_xor = '0; m_stuck = 0; model_clear();

    // R9: start while busy is ignored
    m_ack_delay = 40; m_drop_delay = 3;
    w0 = n_set_wr; d0 = n_done;
    @(negedge clk);
    cmd_set = 0; cmd_opcode = 6'h0C; cmd_port = 8'h44; cmd_data = 16'hA5A5; start = 1;
    @(negedge clk); start = 0;
    settle(10);
    chk(busy == 1'b1, "R9", "busy during exchange", busy, 1);
    cmd_set = 1; cmd_opcode = 6'h33; cmd_port = 8'h99; cmd_data = 16'h0F0F; start = 1;
    @(negedge clk); start = 0;
    begin
      int t = 0;
      while (!done && t < 3000) begin @(negedge clk); t++; end
    end
    chk(status == E_OK && rsp_opcode == 6'h0C, "R9", "first command completes",
        {status, rsp_opcode}, {E_OK, 6'h0C});
    chk(last_set == {2'b10, 6'h0C, 8'h44, 16'hA5A5}, "R9", "busy start not written",
        last_set, {2'b10, 6'h0C, 8'h44, 16'hA5A5});
    settle(200);
    chk(n_done == d0 + 1 && n_set_wr == w0 + 1, "R9", "single exchange",
        {n_done[15:0], n_set_wr[15:0]}, {16'(d0 + 1), 16'(w0 + 1)});

    // R10: status holds between exchanges
    st_hold = status;
    settle(40);
    chk(status == st_hold && busy == 0, "R10", "status held while idle", status, st_hold);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule